// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block turns a single asynchronous serial line into characters. The line rests high. A frame opens with a low start bit, carries 5 to 8 data bits with the least significant bit first, may carry a parity bit, and closes with a high stop bit. All logic runs on one system clock. A sample-tick input gives the receive rate, and it pulses at 1, 16 or 64 times the bit rate.

Four configuration ports set the frame shape: data length, parity enable, parity sense and tick factor. They are captured when a start bit is detected, so a change made while a frame is in flight applies from the next frame. A finished character goes into a one-entry holding register and raises a ready flag. A one-cycle read strobe takes the character and lowers that flag. Framing, parity and overrun problems set sticky flags that stay set until an error-clear pulse.

Top module: `serial_rx`

## Requirements
- R1: After reset, `rx_ready_o`, `rx_data_o` and all three error flags are 0.
- R2: A frame is one low start bit, the data bits least significant first, an optional parity bit, then a stop bit. The character appears on `rx_data_o` with bit 0 holding the first data bit received.
- R3: `len_code_i` sets the data length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Bits of `rx_data_o` above the length read 0.
- R4: With `par_en_i`=1, one parity bit follows the data. With `par_even_i`=0 the data bits plus the parity bit must hold an odd number of ones. With `par_even_i`=1 they must hold an even number. A mismatch sets `parity_err_o`.
- R5: `factor_code_i` sets ticks per bit: 10 gives 16, 11 gives 64, and 01 (or 00) gives 1. In the 1-tick mode, each bit is sampled on the tick after the one that detected the start bit, then on every following tick.
- R6: In the 16 and 64 modes, the start bit is sampled again after half a bit period. If the line is high by then, the frame is dropped and no character is delivered. Later bits are sampled one full bit period apart, counted from that midpoint.
- R7: A stop bit sampled low sets `frame_err_o`. The character is still delivered.
- R8: The three error flags stay at 1 through later frames and reads. They return to 0 only on the cycle after `err_clr_i` is 1.
- R9: While `rx_en_i` is 0, no frame is received. Dropping the enable during a frame abandons that frame.
- R10: `rx_ready_o` rises on the cycle after a character completes. It falls on the cycle after a `rd_strobe_i` pulse.
- R11: If a character completes while `rx_ready_o` is 1 and no read happens in that cycle, `overrun_err_o` is set and the new character replaces the held one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line_i | input | 1 | Serial input line, idle high |
| sample_tick_i | input | 1 | One-cycle pulse at the chosen multiple of the bit rate |
| rx_en_i | input | 1 | Receiver enable |
| len_code_i | input | 2 | Data length code |
| par_en_i | input | 1 | Parity bit present |
| par_even_i | input | 1 | Parity sense: 1 even, 0 odd |
| factor_code_i | input | 2 | Ticks-per-bit code |
| rd_strobe_i | input | 1 | Read pulse, clears ready |
| err_clr_i | input | 1 | Clears the sticky error flags |
| rx_ready_o | output | 1 | Character waiting in the holding register |
| rx_data_o | output | 8 | Held character, right aligned |
| frame_err_o | output | 1 | Sticky framing error |
| parity_err_o | output | 1 | Sticky parity error |
| overrun_err_o | output | 1 | Sticky overrun error |

## Verification
The bench targets several ways a receiver can fail:
- A short low pulse on an idle line. A receiver that does not re-sample at the midpoint would report a spurious character.
- 5-, 6- and 7-bit frames. Wrong alignment would leave the bits shifted or leave stray high bits.
- Both parity senses, with good and with corrupted parity bits. An inverted sense would flag exactly the good frames.
- The 1-tick mode, where an off-by-one start would shift every bit by one position.

It also fills the holding register twice without a read, to confirm that the overrun flag is set and that the newer character wins. It follows a bad-stop frame with a clean frame to confirm that the framing flag survives until it is explicitly cleared.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

   localparam int CHAR_W   = 8;
   localparam int MAX_FAC  = 64;
   localparam int CNT_W    = $clog2(MAX_FAC + 1);
   localparam int NBITS_W  = $clog2(CHAR_W + 1);

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP
   } rx_state_e;

   typedef struct packed {
      logic [NBITS_W-1:0] nbits;
      logic [CNT_W-1:0]   ticks;
      logic               par_on;
      logic               par_even;
   } rx_cfg_t;

   function automatic logic [NBITS_W-1:0] bits_of(input logic [1:0] code);
      return NBITS_W'(5) + NBITS_W'(code);
   endfunction

   function automatic logic [CNT_W-1:0] ticks_of(input logic [1:0] code);
      case (code)
         2'b10:   return CNT_W'(16);
         2'b11:   return CNT_W'(64);
         default: return CNT_W'(1);
      endcase
   endfunction

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("serial_rx_sync: STAGES must be at least 1");
      end

      if (STAGES == 1) begin : g_single
         logic q_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q_r <= RESET_VAL;
            else        q_r <= d_i;
         end
         assign q_o = q_r;
      end else begin : g_chain
         logic [STAGES-1:0] chain_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_r <= {STAGES{RESET_VAL}};
            else        chain_r <= {chain_r[STAGES-2:0], d_i};
         end
         assign q_o = chain_r[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
   import serial_rx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              line_i,
   input  logic              en_i,
   input  logic [1:0]        len_code_i,
   input  logic              par_en_i,
   input  logic              par_even_i,
   input  logic [1:0]        factor_code_i,
   output logic              done_o,
   output logic [CHAR_W-1:0] char_o,
   output logic              par_err_o,
   output logic              frm_err_o
);

   rx_state_e          st_q;
   rx_cfg_t            cfg_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [NBITS_W-1:0] got_q;
   logic [CHAR_W-1:0]  shift_q;
   logic               ones_q;
   logic               perr_q;

   logic [CNT_W-1:0]   cnt_inc;
   logic               bit_due;
   logic               mid_due;
   logic [NBITS_W-1:0] got_inc;
   logic [CHAR_W-1:0]  aligned;
   rx_cfg_t            cfg_new;

   always_comb begin
      cnt_inc          = cnt_q + CNT_W'(1);
      bit_due          = (cnt_inc == cfg_q.ticks);
      mid_due          = (cnt_inc == (cfg_q.ticks >> 1));
      got_inc          = got_q + NBITS_W'(1);
      aligned          = shift_q >> (NBITS_W'(CHAR_W) - cfg_q.nbits);
      cfg_new.nbits    = bits_of(len_code_i);
      cfg_new.ticks    = ticks_of(factor_code_i);
      cfg_new.par_on   = par_en_i;
      cfg_new.par_even = par_even_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         cfg_q     <= '0;
         cnt_q     <= '0;
         got_q     <= '0;
         shift_q   <= '0;
         ones_q    <= 1'b0;
         perr_q    <= 1'b0;
         done_o    <= 1'b0;
         char_o    <= '0;
         par_err_o <= 1'b0;
         frm_err_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (!en_i) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
         end else if (tick_i) begin
            unique case (st_q)
               ST_IDLE: begin
                  if (!line_i) begin
                     cfg_q   <= cfg_new;
                     cnt_q   <= '0;
                     got_q   <= '0;
                     shift_q <= '0;
                     ones_q  <= 1'b0;
                     perr_q  <= 1'b0;
                     st_q    <= (cfg_new.ticks == CNT_W'(1)) ? ST_DATA : ST_START;
                  end
               end
               ST_START: begin
                  if (mid_due) begin
                     cnt_q <= '0;
                     st_q  <= line_i ? ST_IDLE : ST_DATA;
                  end else begin
                     cnt_q <= cnt_inc;
                  end
               end
               ST_DATA: begin
                  if (bit_due) begin
                     cnt_q   <= '0;
                     shift_q <= {line_i, shift_q[CHAR_W-1:1]};
                     ones_q  <= ones_q ^ line_i;
                     got_q   <= got_inc;
                     if (got_inc == cfg_q.nbits)
                        st_q <= cfg_q.par_on ? ST_PAR : ST_STOP;
                  end else begin
                     cnt_q <= cnt_inc;
                  end
               end
               ST_PAR: begin
                  if (bit_due) begin
                     cnt_q  <= '0;
                     perr_q <= ((ones_q ^ line_i) == cfg_q.par_even);
                     st_q   <= ST_STOP;
                  end else begin
                     cnt_q <= cnt_inc;
                  end
               end
               ST_STOP: begin
                  if (bit_due) begin
                     cnt_q     <= '0;
                     done_o    <= 1'b1;
                     char_o    <= aligned;
                     par_err_o <= perr_q;
                     frm_err_o <= ~line_i;
                     st_q      <= ST_IDLE;
                  end else begin
                     cnt_q <= cnt_inc;
                  end
               end
               default: st_q <= ST_IDLE;
            endcase
         end
      end
   end

   // R3
   data_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_DATA) |-> (got_q < cfg_q.nbits));

   // R9
   done_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(en_i));

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

endmodule

// File: rtl/serial_rx_hold.sv
module serial_rx_hold
   import serial_rx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done_i,
   input  logic [CHAR_W-1:0] char_i,
   input  logic              par_err_i,
   input  logic              frm_err_i,
   input  logic              rd_i,
   input  logic              clr_i,
   output logic              ready_o,
   output logic [CHAR_W-1:0] data_o,
   output logic              frm_o,
   output logic              par_o,
   output logic              ovr_o
);

   logic ovr_hit;

   assign ovr_hit = done_i && ready_o && !rd_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready_o <= 1'b0;
         data_o  <= '0;
         frm_o   <= 1'b0;
         par_o   <= 1'b0;
         ovr_o   <= 1'b0;
      end else begin
         if (done_i)    ready_o <= 1'b1;
         else if (rd_i) ready_o <= 1'b0;

         if (done_i) data_o <= char_i;

         if (done_i && frm_err_i) frm_o <= 1'b1;
         else if (clr_i)          frm_o <= 1'b0;

         if (done_i && par_err_i) par_o <= 1'b1;
         else if (clr_i)          par_o <= 1'b0;

         if (ovr_hit)     ovr_o <= 1'b1;
         else if (clr_i)  ovr_o <= 1'b0;
      end
   end

   // R10
   ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready_o) |-> $past(done_i));

   // R11
   ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_o) |-> $past(done_i && ready_o && !rd_i));

   // R8
   frm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(frm_o) |-> $past(clr_i));

endmodule

// File: rtl/serial_rx.sv
module serial_rx
   import serial_rx_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        rx_line_i,
   input  logic        sample_tick_i,
   input  logic        rx_en_i,
   input  logic [1:0]  len_code_i,
   input  logic        par_en_i,
   input  logic        par_even_i,
   input  logic [1:0]  factor_code_i,
   input  logic        rd_strobe_i,
   input  logic        err_clr_i,
   output logic        rx_ready_o,
   output logic [7:0]  rx_data_o,
   output logic        frame_err_o,
   output logic        parity_err_o,
   output logic        overrun_err_o
);

   generate
      if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("serial_rx: SYNC_STAGES must lie in 1..4");
      end
      if (CHAR_W != 8) begin : g_bad_width
         $error("serial_rx: character width must be 8");
      end
   endgenerate

   logic              line_s;
   logic              done_w;
   logic [CHAR_W-1:0] char_w;
   logic              perr_w;
   logic              ferr_w;

   serial_rx_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (rx_line_i),
      .q_o   (line_s)
   );

   serial_rx_frame u_frame (
      .clk           (clk),
      .rst_n         (rst_n),
      .tick_i        (sample_tick_i),
      .line_i        (line_s),
      .en_i          (rx_en_i),
      .len_code_i    (len_code_i),
      .par_en_i      (par_en_i),
      .par_even_i    (par_even_i),
      .factor_code_i (factor_code_i),
      .done_o        (done_w),
      .char_o        (char_w),
      .par_err_o     (perr_w),
      .frm_err_o     (ferr_w)
   );

   serial_rx_hold u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .done_i    (done_w),
      .char_i    (char_w),
      .par_err_i (perr_w),
      .frm_err_i (ferr_w),
      .rd_i      (rd_strobe_i),
      .clr_i     (err_clr_i),
      .ready_o   (rx_ready_o),
      .data_o    (rx_data_o),
      .frm_o     (frame_err_o),
      .par_o     (parity_err_o),
      .ovr_o     (overrun_err_o)
   );

endmodule

// File: tb/serial_rx_bench.sv
`timescale 1ns/1ps
module serial_rx_bench;

   typedef struct packed {
      logic [7:0] d;
      logic       fe;
      logic       pe;
      logic       oe;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_line = 1'b1;
   logic       tick = 1'b0;
   logic       rx_en = 1'b1;
   logic [1:0] len_code = 2'b11;
   logic       par_en = 1'b0;
   logic       par_even = 1'b0;
   logic [1:0] fac_code = 2'b10;
   logic       rd = 1'b0;
   logic       clr = 1'b0;
   logic       ready;
   logic [7:0] data;
   logic       fe, pe, oe;

   int   tcnt = 0;
   int   n_checks = 0;
   int   n_fail = 0;
   bit   mon_on = 1'b0;
   bit   done_flag = 1'b0;
   exp_t exp_q[$];

   always #2.5 clk = ~clk;

   serial_rx u_serial_rx (
      .clk           (clk),
      .rst_n         (rst_n),
      .rx_line_i     (rx_line),
      .sample_tick_i (tick),
      .rx_en_i       (rx_en),
      .len_code_i    (len_code),
      .par_en_i      (par_en),
      .par_even_i    (par_even),
      .factor_code_i (fac_code),
      .rd_strobe_i   (rd),
      .err_clr_i     (clr),
      .rx_ready_o    (ready),
      .rx_data_o     (data),
      .frame_err_o   (fe),
      .parity_err_o  (pe),
      .overrun_err_o (oe)
   );

   // tick every 4 clocks
   initial forever begin
      @(posedge clk);
      tcnt <= (tcnt == 3) ? 0 : tcnt + 1;
      tick <= (tcnt == 3);
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   task automatic hold_ticks(input int n);
      repeat (n) begin
         @(negedge clk);
         while (tcnt != 1) @(negedge clk);
      end
   endtask

   function automatic int fac_of(input logic [1:0] c);
      return (c == 2'b10) ? 16 : (c == 2'b11) ? 64 : 1;
   endfunction

   // drive one frame with the current configuration
   task automatic send(input logic [7:0] d, input bit stop_ok, input bit flip_par);
      int   f  = fac_of(fac_code);
      int   nb = 5 + int'(len_code);
      logic p;
      p = 1'b0;
      hold_ticks(1);
      rx_line = 1'b0;
      hold_ticks(f);
      for (int i = 0; i < nb; i++) begin
         rx_line = d[i];
         p = p ^ d[i];
         hold_ticks(f);
      end
      if (par_en) begin
         rx_line = (par_even ? p : ~p) ^ flip_par;
         hold_ticks(f);
      end
      rx_line = stop_ok;
      hold_ticks(f);
      rx_line = 1'b1;
      hold_ticks(3 * f);
   endtask

   task automatic expect_item(input logic [7:0] d, input bit efe, input bit epe);
      exp_t e;
      int   nb = 5 + int'(len_code);
      e.d  = d & 8'((1 << nb) - 1);
      e.fe = efe;
      e.pe = epe;
      e.oe = 1'b0;
      exp_q.push_back(e);
   endtask

   task automatic pulse(input bit r, input bit c);
      @(negedge clk);
      rd  = r;
      clr = c;
      @(negedge clk);
      rd  = 1'b0;
      clr = 1'b0;
   endtask

   // monitor: pops and compares each delivered character, then reads and clears
   initial forever begin
      @(negedge clk);
      if (mon_on && ready) begin
         exp_t e;
         exp_t a;
         a = {data, fe, pe, oe};
         if (exp_q.size() == 0) begin
            check(1'b0, "R10 unexpected character", 32'(a), 32'h0);
         end else begin
            e = exp_q.pop_front();
            check(a == e, "R2/R3/R4/R7 delivered character", 32'(a), 32'(e));
         end
         rd  = 1'b1;
         clr = 1'b1;
         @(negedge clk);
         rd  = 1'b0;
         clr = 1'b0;
      end
   end

   initial begin
      #750000;
      check(1'b0, "watchdog", 32'h0, 32'h1);
      finish_run();
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      check(ready == 1'b0 && data == 8'h00, "R1 reset ready/data", {23'b0, ready, data}, 32'h0);
      check({fe, pe, oe} == 3'b000, "R1 reset flags", {29'b0, fe, pe, oe}, 32'h0);

      mon_on = 1'b1;
      // R2, R5: 8 bits, 16x
      expect_item(8'h65, 1'b0, 1'b0); send(8'h65, 1'b1, 1'b0);
      expect_item(8'hA3, 1'b0, 1'b0); send(8'hA3, 1'b1, 1'b0);
      // R5: 1x and 64x
      fac_code = 2'b01;
      expect_item(8'h3C, 1'b0, 1'b0); send(8'h3C, 1'b1, 1'b0);
      expect_item(8'hC5, 1'b0, 1'b0); send(8'hC5, 1'b1, 1'b0);
      fac_code = 2'b11;
      expect_item(8'h5A, 1'b0, 1'b0); send(8'h5A, 1'b1, 1'b0);
      // R3: shorter lengths
      fac_code = 2'b10;
      len_code = 2'b00; expect_item(8'hFF, 1'b0, 1'b0); send(8'hFF, 1'b1, 1'b0);
      len_code = 2'b01; expect_item(8'h2A, 1'b0, 1'b0); send(8'h2A, 1'b1, 1'b0);
      len_code = 2'b10; expect_item(8'h55, 1'b0, 1'b0); send(8'h55, 1'b1, 1'b0);
      // R4: parity senses, good and bad
      par_en = 1'b1;
      par_even = 1'b1; expect_item(8'h35, 1'b0, 1'b0); send(8'h35, 1'b1, 1'b0);
      par_even = 1'b0; expect_item(8'h35, 1'b0, 1'b0); send(8'h35, 1'b1, 1'b0);
      par_even = 1'b0; expect_item(8'h35, 1'b0, 1'b1); send(8'h35, 1'b1, 1'b1);
      par_even = 1'b1; expect_item(8'h12, 1'b0, 1'b1); send(8'h12, 1'b1, 1'b1);
      fac_code = 2'b01; len_code = 2'b00; par_even = 1'b0;
      expect_item(8'h0B, 1'b0, 1'b0); send(8'h0B, 1'b1, 1'b0);
      par_en = 1'b0; len_code = 2'b11; fac_code = 2'b10;
      // R7: low stop bit
      expect_item(8'h99, 1'b1, 1'b0); send(8'h99, 1'b0, 1'b0);
      // R6: short low pulse on idle line
      hold_ticks(1);
      rx_line = 1'b0;
      hold_ticks(4);
      rx_line = 1'b1;
      hold_ticks(40);
      check(ready == 1'b0 && exp_q.size() == 0, "R6 glitch rejected", {31'b0, ready}, 32'h0);
      expect_item(8'h81, 1'b0, 1'b0); send(8'h81, 1'b1, 1'b0);
      // R9: disabled receiver ignores a frame
      rx_en = 1'b0;
      send(8'h77, 1'b1, 1'b0);
      check(ready == 1'b0, "R9 disabled ignores frame", {31'b0, ready}, 32'h0);
      rx_en = 1'b1;
      expect_item(8'h42, 1'b0, 1'b0); send(8'h42, 1'b1, 1'b0);
      hold_ticks(4);
      check(exp_q.size() == 0, "R2 all characters delivered", exp_q.size(), 32'h0);

      // R11: overrun, newer character kept
      mon_on = 1'b0;
      send(8'h11, 1'b1, 1'b0);
      check(ready == 1'b1 && data == 8'h11, "R10 ready after first", {23'b0, ready, data}, 32'h111);
      send(8'h22, 1'b1, 1'b0);
      check(oe == 1'b1 && data == 8'h22, "R11 overrun overwrite", {23'b0, oe, data}, 32'h122);
      pulse(1'b1, 1'b0);
      check(ready == 1'b0, "R10 read clears ready", {31'b0, ready}, 32'h0);
      check(oe == 1'b1, "R8 overrun sticky across read", {31'b0, oe}, 32'h1);
      pulse(1'b0, 1'b1);
      check(oe == 1'b0, "R8 clear drops overrun", {31'b0, oe}, 32'h0);

      // R8: framing flag survives a clean frame
      send(8'h0F, 1'b0, 1'b0);
      pulse(1'b1, 1'b0);
      send(8'hF0, 1'b1, 1'b0);
      check(fe == 1'b1 && ready == 1'b1 && data == 8'hF0, "R8 framing sticky",
            {22'b0, fe, ready, data}, 32'h3F0);
      pulse(1'b0, 1'b1);
      check(fe == 1'b0 && ready == 1'b1, "R8 clear leaves character",
            {30'b0, fe, ready}, 32'h1);
      pulse(1'b1, 1'b0);
      check(ready == 1'b0 && oe == 1'b0, "R10 final read", {30'b0, ready, oe}, 32'h0);
      finish_run();
   end

endmodule